// File: doc/BRIEF.md
# Complex Decimate-by-Four Programmable FIR

This block is the final channel filter of a digital down-conversion chain. It takes a complex baseband stream, a real and an imaginary 18-bit sample delivered together under one valid strobe, and filters both parts with the same set of programmable coefficients. It emits one complex result for every fourth accepted sample. The stream typically arrives after integrator-comb stages that have already decimated by two and then by three, so the chain decimates by 24 in total.

A single shared multiplier pair, one for each part, does one tap per clock. The processing clock runs at twice the rate that feeds the integrator-comb chain, so `CYC_PER_IN` = 12 clocks separate two filter inputs at full rate. Four inputs per output therefore give 48 multiply slots, and 48 is the longest filter. Coefficients sit in a small writable memory. The active tap count and both the coefficients and the tap count may be loaded only while the filter is disabled. The wide accumulator is rounded half-up and saturated to a 16, 24 or 32-bit result, which is delivered sign-extended on 32-bit ports.

Top module: `cfir_decim`

## Requirements
- R1: After reset `out_valid` is low, `out_i` and `out_q` are zero, every coefficient is zero and the tap count is 48.
- R2: While `en` is high, exactly one `out_valid` pulse, one cycle long, follows every fourth accepted sample. Counting of accepted samples restarts from zero each time `en` rises.
- R3: The accumulator for output m is the sum over k from 0 to N-1 of c[k]·x[m-k]. Here N is the tap count, x[m] is the fourth sample of the group, and x is zero before the first sample accepted since enable. The real and imaginary parts use the same c[k] and do not mix.
- R4: A pulse on `coef_we` with `en` low stores `coef_data` (signed, 17 fractional bits) as c[`coef_addr`] for addresses below 48. A write with `en` high leaves the coefficients unchanged.
- R5: A pulse on `taps_we` with `en` low loads `taps_val` as the tap count if the value lies between 1 and 48. Any other value, or a write with `en` high, keeps the previous count.
- R6: `out_fmt` selects the result width W: code 0 gives 16, code 1 gives 24, codes 2 and 3 give 32. The result is the accumulator divided by 2^(35-W).
- R7: Rounding is half-up: 2^(34-W) is added before the arithmetic right shift by 35-W bits.
- R8: A rounded value outside the signed W-bit range is clamped to the nearest of -2^(W-1) and 2^(W-1)-1, then sign-extended to 32 bits.
- R9: While `en` is low, samples are ignored, the sample history is cleared to zero, a run in progress is dropped, and `out_valid` stays low from the second cycle on.
- R10: `out_valid` rises N+4 cycles after the clock cycle in which the fourth sample of a group is accepted.
- R11: With samples spaced exactly 12 cycles apart and 48 taps, every result is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter enable; low means idle and configurable |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 18 | Real part of the sample, signed |
| in_q | input | 18 | Imaginary part of the sample, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient index |
| coef_data | input | 18 | Coefficient value, signed |
| taps_we | input | 1 | Tap count write strobe |
| taps_val | input | 6 | Requested tap count |
| out_fmt | input | 2 | Result width code |
| out_valid | output | 1 | Result strobe |
| out_i | output | 32 | Real result, sign-extended |
| out_q | output | 32 | Imaginary result, sign-extended |

## Verification
A wrong history pointer or tap counter shows as a wrong value in the very next result, because each output draws on the whole window. A wrong decimation phase shows as a missing or extra `out_valid` pulse within four samples. Stale history after a disable corrupts the first results of the next run, and the bench predicts those results with zero history. Rounding and clamping faults show only in the low bits or at the extremes, so dedicated cases drive exact half-way values and full-scale inputs.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

    localparam int SAMP_W  = 18;
    localparam int COEF_W  = 18;
    localparam int FRAC_W  = COEF_W - 1;
    localparam int GUARD_W = 6;
    localparam int PROD_W  = SAMP_W + COEF_W;
    localparam int ACC_W   = PROD_W + GUARD_W;
    localparam int OUT_W   = 32;

    typedef enum logic [1:0] {
        FMT_W16     = 2'd0,
        FMT_W24     = 2'd1,
        FMT_W32     = 2'd2,
        FMT_W32_ALT = 2'd3
    } ofmt_e;

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } iq_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } iq_acc_t;

    function automatic int fmt_width(ofmt_e f);
        case (f)
            FMT_W16: return 16;
            FMT_W24: return 24;
            default: return 32;
        endcase
    endfunction

    // Drop 35-W fraction bits with half-up rounding, then clamp to W bits.
    function automatic logic signed [OUT_W-1:0] round_sat(logic signed [ACC_W-1:0] a, ofmt_e f);
        int w;
        int sh;
        logic signed [ACC_W:0] one;
        logic signed [ACC_W:0] ext;
        logic signed [ACC_W:0] q;
        logic signed [ACC_W:0] hi;
        logic signed [ACC_W:0] lo;
        w   = fmt_width(f);
        sh  = SAMP_W + FRAC_W - w;
        one = {{ACC_W{1'b0}}, 1'b1};
        ext = {a[ACC_W-1], a};
        ext = ext + (one <<< (sh - 1));
        q   = ext >>> sh;
        hi  = (one <<< (w - 1)) - one;
        lo  = -(one <<< (w - 1));
        if (q > hi) begin
            q = hi;
        end else if (q < lo) begin
            q = lo;
        end
        return q[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/cfir_hist.sv
module cfir_hist
    import cfir_pkg::*;
#(
    parameter int DEPTH = 52
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     wr_en,
    input  iq_t                      wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    output iq_t                      rd_data,
    output logic [$clog2(DEPTH)-1:0] head
);
    localparam int PW = $clog2(DEPTH);

    iq_t            ring [DEPTH];
    logic [PW-1:0]  head_q;
    logic [PW-1:0]  head_nx;

    assign head_nx = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    assign head    = head_q;
    assign rd_data = ring[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ring[i] <= '0;
            end
        end else if (wr_en) begin
            ring[head_nx] <= wr_data;
            head_q        <= head_nx;
        end
    end

endmodule

// File: rtl/cfir_coef_ram.sv
module cfir_coef_ram
    import cfir_pkg::*;
#(
    parameter int TAPS = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(TAPS)-1:0]  waddr,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [$clog2(TAPS)-1:0]  raddr,
    output logic signed [COEF_W-1:0] rdata
);
    logic signed [COEF_W-1:0] cmem [TAPS];

    assign rdata = cmem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                cmem[i] <= '0;
            end
        end else if (we && (int'(waddr) < TAPS)) begin
            cmem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/cfir_mac.sv
module cfir_mac
    import cfir_pkg::*;
#(
    parameter int DECIM    = 4,
    parameter int MAX_TAPS = 48,
    parameter int DEPTH    = 52
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic                            in_fire,
    input  logic [$clog2(DEPTH)-1:0]        head,
    input  logic [$clog2(MAX_TAPS+1)-1:0]   ntaps,
    output logic [$clog2(MAX_TAPS)-1:0]     coef_addr,
    output logic [$clog2(DEPTH)-1:0]        hist_ptr,
    input  logic signed [COEF_W-1:0]        coef_in,
    input  iq_t                             samp_in,
    output logic                            acc_valid,
    output iq_acc_t                         acc_out,
    output logic                            run_launch,
    output logic                            run_busy,
    output logic                            run_final
);
    localparam int PW   = $clog2(DEPTH);
    localparam int AW   = $clog2(MAX_TAPS);
    localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [PH_W-1:0]          phase;
    logic                     launch;
    logic                     busy;
    logic [AW-1:0]            k;
    logic [PW-1:0]            base;
    logic                     last_tap;

    logic                     p_vld;
    logic                     p_first;
    logic                     p_last;
    logic signed [PROD_W-1:0] p_re;
    logic signed [PROD_W-1:0] p_im;
    logic signed [PROD_W-1:0] mul_re;
    logic signed [PROD_W-1:0] mul_im;

    iq_acc_t                  acc;
    iq_acc_t                  sum;

    assign last_tap   = (int'(k) == int'(ntaps) - 1);
    assign coef_addr  = k;
    assign run_launch = launch;
    assign run_busy   = busy;
    assign run_final  = busy && last_tap;

    // Tap k reads the sample k positions behind the group's newest one.
    always_comb begin
        int p;
        p = int'(base) - int'(k);
        if (p < 0) begin
            p = p + DEPTH;
        end
        hist_ptr = PW'(p);
    end

    assign mul_re = $signed(samp_in.re) * coef_in;
    assign mul_im = $signed(samp_in.im) * coef_in;

    always_comb begin
        sum.re = (p_first ? '0 : acc.re) + {{GUARD_W{p_re[PROD_W-1]}}, p_re};
        sum.im = (p_first ? '0 : acc.im) + {{GUARD_W{p_im[PROD_W-1]}}, p_im};
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase     <= '0;
            launch    <= 1'b0;
            busy      <= 1'b0;
            k         <= '0;
            base      <= '0;
            p_vld     <= 1'b0;
            p_first   <= 1'b0;
            p_last    <= 1'b0;
            p_re      <= '0;
            p_im      <= '0;
            acc       <= '0;
            acc_valid <= 1'b0;
            acc_out   <= '0;
        end else begin
            launch <= in_fire && (int'(phase) == DECIM - 1);
            if (in_fire) begin
                phase <= (int'(phase) == DECIM - 1) ? '0 : phase + 1'b1;
            end

            if (launch) begin
                busy <= 1'b1;
                k    <= '0;
                base <= head;
            end else if (busy) begin
                if (last_tap) begin
                    busy <= 1'b0;
                end else begin
                    k <= k + 1'b1;
                end
            end

            p_vld   <= busy;
            p_first <= busy && (k == '0);
            p_last  <= busy && last_tap;
            p_re    <= mul_re;
            p_im    <= mul_im;

            if (p_vld) begin
                acc <= sum;
            end
            acc_valid <= p_vld && p_last;
            if (p_vld && p_last) begin
                acc_out <= sum;
            end
        end
    end

endmodule

// File: rtl/cfir_decim.sv
module cfir_decim
    import cfir_pkg::*;
#(
    parameter int DECIM      = 4,
    parameter int CYC_PER_IN = 12
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      en,
    input  logic                                      in_valid,
    input  logic [17:0]                               in_i,
    input  logic [17:0]                               in_q,
    input  logic                                      coef_we,
    input  logic [$clog2(DECIM*CYC_PER_IN)-1:0]       coef_addr,
    input  logic [17:0]                               coef_data,
    input  logic                                      taps_we,
    input  logic [$clog2(DECIM*CYC_PER_IN+1)-1:0]     taps_val,
    input  logic [1:0]                                out_fmt,
    output logic                                      out_valid,
    output logic [31:0]                               out_i,
    output logic [31:0]                               out_q
);
    localparam int MAX_TAPS = DECIM * CYC_PER_IN;
    localparam int DEPTH    = MAX_TAPS + DECIM;
    localparam int PW       = $clog2(DEPTH);
    localparam int AW       = $clog2(MAX_TAPS);
    localparam int CW       = $clog2(MAX_TAPS + 1);

    logic [CW-1:0]            ntaps;
    logic                     in_fire;
    iq_t                      samp_w;
    iq_t                      samp_r;
    logic [PW-1:0]            head;
    logic [PW-1:0]            hist_ptr;
    logic [AW-1:0]            c_raddr;
    logic signed [COEF_W-1:0] c_rdata;
    logic                     acc_valid;
    iq_acc_t                  acc_out;
    logic                     run_launch;
    logic                     run_busy;
    logic                     run_final;

    assign in_fire   = en && in_valid;
    assign samp_w.re = $signed(in_i);
    assign samp_w.im = $signed(in_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ntaps <= CW'(MAX_TAPS);
        end else if (taps_we && !en && (taps_val != '0) && (int'(taps_val) <= MAX_TAPS)) begin
            ntaps <= taps_val;
        end
    end

    cfir_hist #(.DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en),
        .wr_en   (in_fire),
        .wr_data (samp_w),
        .rd_ptr  (hist_ptr),
        .rd_data (samp_r),
        .head    (head)
    );

    cfir_coef_ram #(.TAPS(MAX_TAPS)) u_coef (
        .clk   (clk),
        .rst   (rst),
        .we    (coef_we && !en),
        .waddr (coef_addr),
        .wdata ($signed(coef_data)),
        .raddr (c_raddr),
        .rdata (c_rdata)
    );

    cfir_mac #(.DECIM(DECIM), .MAX_TAPS(MAX_TAPS), .DEPTH(DEPTH)) u_mac (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .in_fire    (in_fire),
        .head       (head),
        .ntaps      (ntaps),
        .coef_addr  (c_raddr),
        .hist_ptr   (hist_ptr),
        .coef_in    (c_rdata),
        .samp_in    (samp_r),
        .acc_valid  (acc_valid),
        .acc_out    (acc_out),
        .run_launch (run_launch),
        .run_busy   (run_busy),
        .run_final  (run_final)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= acc_valid;
            if (acc_valid) begin
                out_i <= round_sat(acc_out.re, ofmt_e'(out_fmt));
                out_q <= round_sat(acc_out.im, ofmt_e'(out_fmt));
            end
        end
    end

endmodule

// File: rtl/cfir_decim_chk.sv
module cfir_decim_chk #(
    parameter int MAX_TAPS = 48
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          en,
    input logic                          taps_we,
    input logic [1:0]                    out_fmt,
    input logic                          out_valid,
    input logic [31:0]                   out_i,
    input logic [31:0]                   out_q,
    input logic [$clog2(MAX_TAPS+1)-1:0] ntaps,
    input logic                          run_launch,
    input logic                          run_busy,
    input logic                          run_final
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_i == '0 && out_q == '0));

    // R5
    taps_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ntaps != '0) && (int'(ntaps) <= MAX_TAPS));

    // R5
    taps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (taps_we && en) |=> $stable(ntaps));

    // R9
    disable_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ##1 !out_valid);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R11
    run_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        run_launch |-> (!run_busy || run_final));

    // R8
    fmt16_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_fmt) == 2'd0) |->
        (out_i[31:15] == {17{out_i[15]}} && out_q[31:15] == {17{out_q[15]}}));

    // R8
    fmt24_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_fmt) == 2'd1) |->
        (out_i[31:23] == {9{out_i[23]}} && out_q[31:23] == {9{out_q[23]}}));

endmodule

bind cfir_decim cfir_decim_chk #(.MAX_TAPS(MAX_TAPS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .taps_we    (taps_we),
    .out_fmt    (out_fmt),
    .out_valid  (out_valid),
    .out_i      (out_i),
    .out_q      (out_q),
    .ntaps      (ntaps),
    .run_launch (run_launch),
    .run_busy   (run_busy),
    .run_final  (run_final)
);

// File: tb/cfir_decim_test.sv
module cfir_decim_test;
    localparam int CLK_PERIOD = 10;
    localparam int DECIM      = 4;
    localparam int CYC        = 12;
    localparam int NT         = DECIM * CYC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_i = '0;
    logic [17:0] in_q = '0;
    logic        coef_we = 1'b0;
    logic [5:0]  coef_addr = '0;
    logic [17:0] coef_data = '0;
    logic        taps_we = 1'b0;
    logic [5:0]  taps_val = '0;
    logic [1:0]  out_fmt = 2'd2;
    logic        out_valid;
    logic [31:0] out_i;
    logic [31:0] out_q;

    cfir_decim #(.DECIM(DECIM), .CYC_PER_IN(CYC)) uut (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .taps_we(taps_we), .taps_val(taps_val), .out_fmt(out_fmt),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_out = 0;
    longint o_re [0:255];
    longint o_im [0:255];
    int     o_t  [0:255];
    int     t_in [0:1023];
    int     s_re [0:1023];
    int     s_im [0:1023];
    int     mc   [0:NT-1];
    int     mtaps = NT;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (n_out < 256) begin
                o_re[n_out] = longint'($signed(out_i));
                o_im[n_out] = longint'($signed(out_q));
                o_t[n_out]  = cyc;
            end
            n_out = n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint rs(input longint a, input int fmt);
        int w;
        int sh;
        longint q;
        longint hi;
        longint lo;
        w  = (fmt == 0) ? 16 : (fmt == 1) ? 24 : 32;
        sh = 35 - w;
        q  = (a + (64'sd1 <<< (sh - 1))) >>> sh;
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -(64'sd1 <<< (w - 1));
        if (q > hi) q = hi;
        if (q < lo) q = lo;
        return q;
    endfunction

    function automatic longint expect_out(input int m, input bit im, input int fmt);
        longint acc = 0;
        for (int k = 0; k < mtaps; k++) begin
            if (m - k >= 0) begin
                acc += longint'(mc[k]) * longint'(im ? s_im[m-k] : s_re[m-k]);
            end
        end
        return rs(acc, fmt);
    endfunction

    int rtab_re [0:3] = '{4, -4, -5, 3};
    int rtab_im [0:3] = '{12, -12, 11, -3};

    function automatic int gen(input int pat, input int m, input bit im);
        case (pat)
            0: return (m == 0) ? (im ? -50000 : 70000) : 0;
            1: return ((m * 7919 + (im ? 3 : 0) * 1237 + 12345) % 262144) - 131072;
            2: return im ? -131072 : 131071;
            default: return im ? rtab_im[(m / 4) % 4] : rtab_re[(m / 4) % 4];
        endcase
    endfunction

    task automatic wr_coef(input int a, input int v);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 6'(a); coef_data = 18'(v);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic wr_taps(input int v);
        @(negedge clk);
        taps_we = 1'b1; taps_val = 6'(v);
        @(negedge clk);
        taps_we = 1'b0;
    endtask

    task automatic load_coefs(input int kind);
        for (int k = 0; k < NT; k++) begin
            int v;
            v = (kind == 0) ? ((k + 1) * 1500 - 30000) :
                (kind == 1) ? 131071 :
                (kind == 2) ? ((k == 0) ? 1 : 77) : ((k * 3001) % 60000) - 30000;
            mc[k] = v;
            wr_coef(k, v);
        end
    endtask

    // One full run: disable (clears history), enable, feed at full rate, compare.
    task automatic run_stream(input int nsamp, input int pat, input int fmt, input string req);
        @(negedge clk);
        en = 1'b0;
        out_fmt = 2'(fmt);
        repeat (3) @(negedge clk);
        n_out = 0;
        en = 1'b1;
        for (int m = 0; m < nsamp; m++) begin
            s_re[m] = gen(pat, m, 1'b0);
            s_im[m] = gen(pat, m, 1'b1);
            @(negedge clk);
            in_valid = 1'b1; in_i = 18'(s_re[m]); in_q = 18'(s_im[m]);
            t_in[m] = cyc;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (CYC - 2) @(negedge clk);
        end
        repeat (mtaps + 10) @(negedge clk);
        // R2 one result per four samples
        chk(n_out == nsamp / DECIM, "R2", "output count", n_out, nsamp / DECIM);
        for (int j = 0; j < n_out && j < nsamp / DECIM; j++) begin
            longint er;
            longint ei;
            er = expect_out(DECIM * j + DECIM - 1, 1'b0, fmt);
            ei = expect_out(DECIM * j + DECIM - 1, 1'b1, fmt);
            chk(o_re[j] == er, req, "real result", o_re[j], er);
            chk(o_im[j] == ei, req, "imag result", o_im[j], ei);
            // R10 latency N+4
            chk(o_t[j] - t_in[DECIM * j + DECIM - 1] == mtaps + 4, "R10", "latency",
                o_t[j] - t_in[DECIM * j + DECIM - 1], mtaps + 4);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        // R1 quiet outputs after reset
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(out_i == '0 && out_q == '0, "R1", "outputs", out_i, 0);
        for (int k = 0; k < NT; k++) mc[k] = 0;
        mtaps = NT;
        // R1 zero coefficients and 48 taps seen through results and latency
        run_stream(12, 1, 2, "R1");
    endtask

    task automatic test_impulse();
        en = 1'b0;
        load_coefs(0);
        // R3 R11 impulse at full rate with 48 taps
        run_stream(56, 0, 2, "R3");
    endtask

    task automatic test_mixed();
        en = 1'b0;
        load_coefs(3);
        // R6 24-bit and alternate 32-bit codes
        run_stream(40, 1, 1, "R6");
        run_stream(20, 1, 3, "R6");
        // R11 sustained rate with dense data
        run_stream(40, 1, 2, "R11");
    endtask

    task automatic test_coef_lock();
        @(negedge clk);
        en = 1'b1;
        // R4 writes while enabled must not land
        wr_coef(0, 99999);
        wr_coef(7, -88888);
        run_stream(24, 1, 2, "R4");
    endtask

    task automatic test_taps();
        en = 1'b0;
        wr_taps(10);
        mtaps = 10;
        run_stream(24, 1, 2, "R5");
        en = 1'b0;
        wr_taps(49);
        wr_taps(0);
        @(negedge clk);
        en = 1'b1;
        wr_taps(20);
        // R5 rejected values keep ten taps
        run_stream(24, 1, 2, "R5");
    endtask

    task automatic test_round();
        en = 1'b0;
        load_coefs(2);
        wr_taps(1);
        mtaps = 1;
        // R7 half-up on exact halves
        run_stream(16, 3, 2, "R7");
        chk(o_re[1] == 0 && o_re[2] == -1, "R7", "halfway real", o_re[1], 0);
        chk(o_im[0] == 2 && o_im[1] == -1, "R7", "halfway imag", o_im[1], -1);
    endtask

    task automatic test_sat();
        en = 1'b0;
        load_coefs(1);
        wr_taps(NT);
        mtaps = NT;
        // R8 clamping at 16 and 24 bits
        run_stream(16, 2, 0, "R8");
        chk(o_re[3] == 32767 && o_im[3] == -32768, "R8", "16-bit clamp", o_re[3], 32767);
        run_stream(16, 2, 1, "R8");
        chk(o_re[3] == 8388607 && o_im[3] == -8388608, "R8", "24-bit clamp", o_re[3], 8388607);
    endtask

    task automatic test_disable();
        en = 1'b0;
        load_coefs(3);
        run_stream(20, 1, 2, "R9");
        @(negedge clk);
        en = 1'b0;
        n_out = 0;
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            in_valid = 1'b1; in_i = 18'(40000 + m); in_q = 18'(-40000 - m);
            @(negedge clk);
            in_valid = 1'b0;
        end
        repeat (NT + 10) @(negedge clk);
        // R9 ignored samples while disabled
        chk(n_out == 0, "R9", "outputs while disabled", n_out, 0);
        // R9 cleared history shows in the next run
        run_stream(20, 0, 2, "R9");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_impulse();
        test_mixed();
        test_coef_lock();
        test_taps();
        test_round();
        test_sat();
        test_disable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule